// File: doc/BRIEF.md
# Accumulator Execute Stage with Selective Flag Update

This block is the execute stage of a small 8-bit accumulator machine. Each cycle in which `in_valid` is high, it takes a decoded 5-bit operation code, the working register value, a file-register operand, an immediate literal, a destination-select bit and the current status byte. One clock edge later it presents the 8-bit result, a write strobe for either the working register or the file register (never both), the new status byte and a zero-result flag for counting operations.

The status byte carries three arithmetic flags: carry, digit carry (the carry out of the low nibble) and zero. Each operation changes only the flags it is defined to touch. All other bits of the status byte pass through from the input unchanged. Subtraction takes the working register away from the operand, and carry then acts as an inverted borrow. Rotate-left through carry and nibble exchange are also provided. Fetch, opcode decode, register-file storage and skip or branch handling are left to the sequencer that drives this block.

Top module: `alu_exec_stage`

## Requirements
- R1: Outputs are registered. A valid operation sampled at a rising edge appears on `result`, `w_we`, `f_we`, `status_out` and `zero_hit` after that edge, with `out_valid` high. When `in_valid` is low at an edge, `out_valid`, `w_we`, `f_we` and `zero_hit` go low. Reset clears every output to zero.
- R2: Literal codes 1 (add), 2 (subtract), 3 (AND), 4 (OR), 5 (XOR) and 6 (load) use `lit_val` as the operand and always assert `w_we` only, whatever `dest_f` is.
- R3: File codes 7–15, 19 and 20 use `f_val` as the operand. They assert `w_we` when `dest_f`=0 and `f_we` when `dest_f`=1. Code 16 (store W) and code 17 (clear file) always assert `f_we`. Code 18 (clear W) always asserts `w_we`.
- R4: Add (codes 1, 7) gives W + operand mod 256. C is the carry out of bit 7, DC is the carry out of bit 3, and Z is set when the result is zero.
- R5: Subtract (codes 2, 8) gives operand − W mod 256. C is 1 when no borrow occurs out of bit 7, and DC is 1 when no borrow occurs out of bit 3. Z is set when the result is zero.
- R6: AND (3, 9), OR (4, 10), XOR (5, 11), complement of f (12) and move of f (15) update Z only.
- R7: Decrement (13) and increment (14) of f wrap modulo 256 and update Z only. `zero_hit` is high exactly when such an operation yields zero, and is low for every other operation.
- R8: Rotate-left (19) gives {f[6:0], old C}. The new C is f[7], and only C changes.
- R9: Swap (20) exchanges the two nibbles of f and changes no flag.
- R10: Clear file (17) and clear W (18) give 0 and set Z. Load literal (6) gives `lit_val` and store W (16) gives `w_val`; neither changes any flag.
- R11: Status byte layout: C is bit 0, DC is bit 1 and Z is bit 2. Bits 7:3, and any flag the operation does not affect, are copied from `status_in`.
- R12: Code 0 and codes 21–31 perform no operation. Both write strobes and `zero_hit` stay low, `result` is 0 and `status_out` equals `status_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| op_code | input | 5 | Operation select (codes in R2–R12) |
| w_val | input | 8 | Working register value |
| f_val | input | 8 | File register operand |
| lit_val | input | 8 | Immediate literal |
| dest_f | input | 1 | 0 = result to W, 1 = result to file register |
| status_in | input | 8 | Current status byte |
| out_valid | output | 1 | Registered outputs belong to a valid operation |
| result | output | 8 | Operation result |
| w_we | output | 1 | Write result to working register |
| f_we | output | 1 | Write result to file register |
| status_out | output | 8 | Updated status byte |
| zero_hit | output | 1 | Increment or decrement produced zero |

## Verification
Every result of this block, including the write strobes, the status byte and `zero_hit`, is due exactly one rising edge after the operation is sampled, and there is no further latency. The bench applies each operation on a falling edge and records its behaviourally computed expectation. At the next falling edge, after the single capturing edge, it compares all outputs against that expectation. Idle cycles are checked at the same offset for deasserted strobes. Directed corner cases (nibble carries, borrows, wrap to zero, rotate with carry set, undefined codes) come before a long random mix of codes, destination bits and status bytes.

// File: rtl/alu_exec_pkg.sv
package alu_exec_pkg;

    localparam int OPC_W   = 5;
    localparam int FLAG_C  = 0;
    localparam int FLAG_DC = 1;
    localparam int FLAG_Z  = 2;

    typedef enum logic [OPC_W-1:0] {
        OP_NOP     = 5'd0,
        OP_ADD_K   = 5'd1,
        OP_SUB_K   = 5'd2,
        OP_AND_K   = 5'd3,
        OP_OR_K    = 5'd4,
        OP_XOR_K   = 5'd5,
        OP_LOAD_K  = 5'd6,
        OP_ADD_F   = 5'd7,
        OP_SUB_F   = 5'd8,
        OP_AND_F   = 5'd9,
        OP_OR_F    = 5'd10,
        OP_XOR_F   = 5'd11,
        OP_CPL_F   = 5'd12,
        OP_DEC_F   = 5'd13,
        OP_INC_F   = 5'd14,
        OP_PASS_F  = 5'd15,
        OP_STORE_W = 5'd16,
        OP_CLR_F   = 5'd17,
        OP_CLR_W   = 5'd18,
        OP_ROL_F   = 5'd19,
        OP_SWAP_F  = 5'd20
    } op_e;

    typedef enum logic [3:0] {
        FN_NONE, FN_ADD, FN_SUB, FN_AND, FN_OR, FN_XOR, FN_PASS_OPND,
        FN_PASS_W, FN_CPL, FN_DEC, FN_INC, FN_ZERO, FN_ROL, FN_SWAP
    } func_e;

    typedef struct packed {
        func_e fn;
        logic  use_lit;
        logic  wr_w;
        logic  wr_f;
        logic  upd_z;
        logic  upd_dc;
        logic  upd_c;
        logic  count_op;
    } ctl_t;

endpackage

// File: rtl/alu_exec_decode.sv
module alu_exec_decode
    import alu_exec_pkg::*;
(
    input  logic [OPC_W-1:0] op_i,
    input  logic             dest_f_i,
    output ctl_t             ctl_o
);

    always_comb begin
        ctl_o = '0;
        unique case (op_i)
            OP_ADD_K:   begin ctl_o.fn = FN_ADD; ctl_o.use_lit = 1'b1; ctl_o.wr_w = 1'b1;
                              ctl_o.upd_z = 1'b1; ctl_o.upd_dc = 1'b1; ctl_o.upd_c = 1'b1; end
            OP_SUB_K:   begin ctl_o.fn = FN_SUB; ctl_o.use_lit = 1'b1; ctl_o.wr_w = 1'b1;
                              ctl_o.upd_z = 1'b1; ctl_o.upd_dc = 1'b1; ctl_o.upd_c = 1'b1; end
            OP_AND_K:   begin ctl_o.fn = FN_AND; ctl_o.use_lit = 1'b1; ctl_o.wr_w = 1'b1;
                              ctl_o.upd_z = 1'b1; end
            OP_OR_K:    begin ctl_o.fn = FN_OR;  ctl_o.use_lit = 1'b1; ctl_o.wr_w = 1'b1;
                              ctl_o.upd_z = 1'b1; end
            OP_XOR_K:   begin ctl_o.fn = FN_XOR; ctl_o.use_lit = 1'b1; ctl_o.wr_w = 1'b1;
                              ctl_o.upd_z = 1'b1; end
            OP_LOAD_K:  begin ctl_o.fn = FN_PASS_OPND; ctl_o.use_lit = 1'b1; ctl_o.wr_w = 1'b1; end
            OP_ADD_F:   begin ctl_o.fn = FN_ADD; ctl_o.upd_z = 1'b1; ctl_o.upd_dc = 1'b1;
                              ctl_o.upd_c = 1'b1; end
            OP_SUB_F:   begin ctl_o.fn = FN_SUB; ctl_o.upd_z = 1'b1; ctl_o.upd_dc = 1'b1;
                              ctl_o.upd_c = 1'b1; end
            OP_AND_F:   begin ctl_o.fn = FN_AND; ctl_o.upd_z = 1'b1; end
            OP_OR_F:    begin ctl_o.fn = FN_OR;  ctl_o.upd_z = 1'b1; end
            OP_XOR_F:   begin ctl_o.fn = FN_XOR; ctl_o.upd_z = 1'b1; end
            OP_CPL_F:   begin ctl_o.fn = FN_CPL; ctl_o.upd_z = 1'b1; end
            OP_DEC_F:   begin ctl_o.fn = FN_DEC; ctl_o.upd_z = 1'b1; ctl_o.count_op = 1'b1; end
            OP_INC_F:   begin ctl_o.fn = FN_INC; ctl_o.upd_z = 1'b1; ctl_o.count_op = 1'b1; end
            OP_PASS_F:  begin ctl_o.fn = FN_PASS_OPND; ctl_o.upd_z = 1'b1; end
            OP_STORE_W: begin ctl_o.fn = FN_PASS_W; ctl_o.wr_f = 1'b1; end
            OP_CLR_F:   begin ctl_o.fn = FN_ZERO; ctl_o.wr_f = 1'b1; ctl_o.upd_z = 1'b1; end
            OP_CLR_W:   begin ctl_o.fn = FN_ZERO; ctl_o.wr_w = 1'b1; ctl_o.upd_z = 1'b1; end
            OP_ROL_F:   begin ctl_o.fn = FN_ROL; ctl_o.upd_c = 1'b1; end
            OP_SWAP_F:  begin ctl_o.fn = FN_SWAP; end
            default:    ctl_o = '0;
        endcase

        // file-register operations that follow the destination bit
        if (ctl_o.fn != FN_NONE && !ctl_o.use_lit &&
            op_i != OP_STORE_W && op_i != OP_CLR_F && op_i != OP_CLR_W) begin
            ctl_o.wr_w = ~dest_f_i;
            ctl_o.wr_f = dest_f_i;
        end
    end

endmodule

// File: rtl/alu_exec_addsub.sv
module alu_exec_addsub #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              sub_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              c_o,
    output logic              dc_o
);

    localparam int HALF = DATA_W / 2;

    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   full;

    // subtraction as a + ~b + 1, so carry out means "no borrow"
    assign b_eff = sub_i ? ~b_i : b_i;
    assign full  = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub_i};
    assign sum_o = full[DATA_W-1:0];
    assign c_o   = full[DATA_W];
    // carry into bit HALF recovered from the sum bit and its two inputs
    assign dc_o  = a_i[HALF] ^ b_eff[HALF] ^ full[HALF];

endmodule

// File: rtl/alu_exec_logic.sv
module alu_exec_logic
    import alu_exec_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  func_e             fn_i,
    input  logic [DATA_W-1:0] w_i,
    input  logic [DATA_W-1:0] opnd_i,
    input  logic              carry_i,
    output logic [DATA_W-1:0] res_o,
    output logic              rot_c_o
);

    localparam int HALF = DATA_W / 2;

    always_comb begin
        res_o   = '0;
        rot_c_o = opnd_i[DATA_W-1];
        unique case (fn_i)
            FN_AND:       res_o = w_i & opnd_i;
            FN_OR:        res_o = w_i | opnd_i;
            FN_XOR:       res_o = w_i ^ opnd_i;
            FN_PASS_OPND: res_o = opnd_i;
            FN_PASS_W:    res_o = w_i;
            FN_CPL:       res_o = ~opnd_i;
            FN_DEC:       res_o = opnd_i - DATA_W'(1);
            FN_INC:       res_o = opnd_i + DATA_W'(1);
            FN_ZERO:      res_o = '0;
            FN_ROL:       res_o = {opnd_i[DATA_W-2:0], carry_i};
            FN_SWAP:      res_o = {opnd_i[HALF-1:0], opnd_i[DATA_W-1:HALF]};
            default:      res_o = '0;
        endcase
    end

endmodule

// File: rtl/alu_exec_stage.sv
module alu_exec_stage
    import alu_exec_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OPC_W-1:0]  op_code,
    input  logic [DATA_W-1:0] w_val,
    input  logic [DATA_W-1:0] f_val,
    input  logic [DATA_W-1:0] lit_val,
    input  logic              dest_f,
    input  logic [STAT_W-1:0] status_in,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              w_we,
    output logic              f_we,
    output logic [STAT_W-1:0] status_out,
    output logic              zero_hit
);

    ctl_t              ctl;
    logic [DATA_W-1:0] opnd;
    logic [DATA_W-1:0] as_a, as_b, as_sum, lg_res, res;
    logic              as_c, as_dc, rot_c, res_zero;
    logic [STAT_W-1:0] st_next;

    alu_exec_decode u_dec (
        .op_i     (op_code),
        .dest_f_i (dest_f),
        .ctl_o    (ctl)
    );

    assign opnd = ctl.use_lit ? lit_val : f_val;

    // add: W + operand ; subtract: operand - W
    assign as_a = (ctl.fn == FN_SUB) ? opnd  : w_val;
    assign as_b = (ctl.fn == FN_SUB) ? w_val : opnd;

    alu_exec_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a_i   (as_a),
        .b_i   (as_b),
        .sub_i (ctl.fn == FN_SUB),
        .sum_o (as_sum),
        .c_o   (as_c),
        .dc_o  (as_dc)
    );

    alu_exec_logic #(.DATA_W(DATA_W)) u_logic (
        .fn_i    (ctl.fn),
        .w_i     (w_val),
        .opnd_i  (opnd),
        .carry_i (status_in[FLAG_C]),
        .res_o   (lg_res),
        .rot_c_o (rot_c)
    );

    assign res      = (ctl.fn == FN_ADD || ctl.fn == FN_SUB) ? as_sum : lg_res;
    assign res_zero = (res == '0);

    always_comb begin
        st_next = status_in;
        if (ctl.upd_z)  st_next[FLAG_Z]  = res_zero;
        if (ctl.upd_dc) st_next[FLAG_DC] = as_dc;
        if (ctl.upd_c)  st_next[FLAG_C]  = (ctl.fn == FN_ROL) ? rot_c : as_c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            w_we       <= 1'b0;
            f_we       <= 1'b0;
            zero_hit   <= 1'b0;
            result     <= '0;
            status_out <= '0;
        end else begin
            out_valid <= in_valid;
            w_we      <= in_valid & ctl.wr_w;
            f_we      <= in_valid & ctl.wr_f;
            zero_hit  <= in_valid & ctl.count_op & res_zero;
            if (in_valid) begin
                result     <= res;
                status_out <= st_next;
            end
        end
    end

endmodule

// File: rtl/alu_exec_checker.sv
module alu_exec_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [4:0] op_code,
    input logic [7:0] status_in,
    input logic       out_valid,
    input logic [7:0] result,
    input logic       w_we,
    input logic       f_we,
    input logic [7:0] status_out,
    input logic       zero_hit
);

    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && !w_we && !f_we && !zero_hit); // R1

    AST_LITERAL_TO_W: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op_code >= 5'd1 && op_code <= 5'd6 |=> w_we && !f_we); // R2

    AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        !(w_we && f_we)); // R3

    AST_ZERO_HIT_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        zero_hit |-> result == 8'h00); // R7

    AST_ROL_ONLY_C: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op_code == 5'd19 |=> status_out[7:1] == $past(status_in[7:1])); // R8

    AST_SWAP_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op_code == 5'd20 |=> status_out == $past(status_in)); // R9

    AST_CLEAR_SETS_Z: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (op_code == 5'd17 || op_code == 5'd18) |=> result == 8'h00 && status_out[2]); // R10

    AST_UPPER_STATUS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> status_out[7:3] == $past(status_in[7:3])); // R11

    AST_UNDEFINED_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (op_code == 5'd0 || op_code >= 5'd21)
        |=> !w_we && !f_we && status_out == $past(status_in)); // R12

endmodule

bind alu_exec_stage alu_exec_checker u_alu_exec_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .op_code    (op_code),
    .status_in  (status_in),
    .out_valid  (out_valid),
    .result     (result),
    .w_we       (w_we),
    .f_we       (f_we),
    .status_out (status_out),
    .zero_hit   (zero_hit)
);

// File: tb/test_alu_exec_stage.sv
module test_alu_exec_stage;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [4:0] op_code = '0;
    logic [7:0] w_val = '0, f_val = '0, lit_val = '0, status_in = '0;
    logic       dest_f = 1'b0;
    logic       out_valid, w_we, f_we, zero_hit;
    logic [7:0] result, status_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    alu_exec_stage i_alu_exec_stage (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
        .w_val(w_val), .f_val(f_val), .lit_val(lit_val), .dest_f(dest_f),
        .status_in(status_in), .out_valid(out_valid), .result(result),
        .w_we(w_we), .f_we(f_we), .status_out(status_out), .zero_hit(zero_hit)
    );

    typedef struct {
        bit   act;
        int   res;
        bit   ww;
        bit   fw;
        int   st;
        bit   zh;
        int   op;
    } exp_t;

    exp_t pend;
    bit   have_pend = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic string fn_req(input int op);
        if (op == 1 || op == 7) return "R4";
        if (op == 2 || op == 8) return "R5";
        if (op == 13 || op == 14) return "R7";
        if (op == 19) return "R8";
        if (op == 20) return "R9";
        if (op == 6 || (op >= 16 && op <= 18)) return "R10";
        if (op >= 3 && op <= 15) return "R6";
        return "R12";
    endfunction

    function automatic string dst_req(input int op);
        if (op >= 1 && op <= 6) return "R2";
        if (op >= 7 && op <= 20) return "R3";
        return "R12";
    endfunction

    // behavioural reference for one operation
    function automatic exp_t model(input int op, input int w, input int f,
                                   input int k, input bit d, input int st);
        exp_t e;
        int   opd, r, c, dc;
        bit   uz, udc, uc, to_w, to_f;
        opd = (op >= 1 && op <= 6) ? k : f;
        r = 0; c = 0; dc = 0; uz = 0; udc = 0; uc = 0;
        e.zh = 0;
        case (op)
            1, 7:   begin r = (w + opd) % 256; c = (w + opd) > 255;
                          dc = ((w % 16) + (opd % 16)) > 15; uz = 1; udc = 1; uc = 1; end
            2, 8:   begin r = (opd - w + 256) % 256; c = (opd >= w);
                          dc = ((opd % 16) >= (w % 16)); uz = 1; udc = 1; uc = 1; end
            3, 9:   begin r = w & opd; uz = 1; end
            4, 10:  begin r = w | opd; uz = 1; end
            5, 11:  begin r = w ^ opd; uz = 1; end
            6:      r = k;
            12:     begin r = 255 - f; uz = 1; end
            13:     begin r = (f + 255) % 256; uz = 1; e.zh = (r == 0); end
            14:     begin r = (f + 1) % 256; uz = 1; e.zh = (r == 0); end
            15:     begin r = f; uz = 1; end
            16:     r = w;
            17, 18: begin r = 0; uz = 1; end
            19:     begin r = ((f * 2) % 256) + (st % 2); c = (f >= 128); uc = 1; end
            20:     r = (f % 16) * 16 + f / 16;
            default: r = 0;
        endcase
        to_w = 0; to_f = 0;
        if (op >= 1 && op <= 6) to_w = 1;
        else if ((op >= 7 && op <= 15) || op == 19 || op == 20) begin to_w = !d; to_f = d; end
        else if (op == 16 || op == 17) to_f = 1;
        else if (op == 18) to_w = 1;
        e.st = st;
        if (uz)  e.st = (e.st & ~4) | ((r == 0) ? 4 : 0);
        if (udc) e.st = (e.st & ~2) | (dc ? 2 : 0);
        if (uc)  e.st = (e.st & ~1) | (c ? 1 : 0);
        e.res = r; e.ww = to_w; e.fw = to_f; e.op = op; e.act = 1;
        return e;
    endfunction

    task automatic compare_pending();
        if (!have_pend) return;
        if (pend.act) begin
            check(out_valid == 1'b1, "R1", "out_valid", out_valid, 1);
            check(result == pend.res[7:0], fn_req(pend.op), "result", result, pend.res);
            check(w_we == pend.ww, dst_req(pend.op), "w_we", w_we, pend.ww);
            check(f_we == pend.fw, dst_req(pend.op), "f_we", f_we, pend.fw);
            check(status_out[2:0] == pend.st[2:0], fn_req(pend.op), "flags",
                  status_out[2:0], pend.st % 8);
            check(status_out[7:3] == pend.st[7:3], "R11", "status upper",
                  status_out, pend.st);
            check(zero_hit == pend.zh, "R7", "zero_hit", zero_hit, pend.zh);
        end else begin
            check(!out_valid && !w_we && !f_we && !zero_hit, "R1", "idle strobes",
                  {out_valid, w_we, f_we, zero_hit}, 0);
        end
    endtask

    // apply one cycle of stimulus on the falling edge, checking the previous one
    task automatic step(input bit v, input int op, input int w, input int f,
                        input int k, input bit d, input int st);
        @(negedge clk);
        compare_pending();
        in_valid  = v;
        op_code   = op[4:0];
        w_val     = w[7:0];
        f_val     = f[7:0];
        lit_val   = k[7:0];
        dest_f    = d;
        status_in = st[7:0];
        if (v) pend = model(op, w, f, k, d, st);
        else   pend.act = 0;
        have_pend = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!out_valid && !w_we && !f_we && !zero_hit && result == 0 && status_out == 0,
              "R1", "reset outputs", {out_valid, w_we, f_we, zero_hit, result, status_out}, 0);
        rst_n = 1'b1;

        // R4 add: nibble carry, full carry to zero
        step(1, 1, 8'h0F, 0, 8'h01, 1, 8'hF8);
        step(1, 7, 8'hFF, 8'h01, 0, 1, 8'h00);
        // R5 subtract: equal, borrow, low-nibble borrow only
        step(1, 2, 8'h33, 0, 8'h33, 0, 8'h00);
        step(1, 8, 8'h05, 8'h03, 0, 0, 8'h07);
        step(1, 8, 8'h0F, 8'h20, 0, 1, 8'h00);
        // R7 wrap and zero_hit
        step(1, 14, 0, 8'hFF, 0, 1, 8'h00);
        step(1, 13, 0, 8'h01, 0, 0, 8'h00);
        step(1, 13, 0, 8'h00, 0, 1, 8'h04);
        step(0, 0, 0, 0, 0, 0, 0);
        // R8 rotate with carry in and msb out
        step(1, 19, 0, 8'h80, 0, 1, 8'h01);
        step(1, 19, 0, 8'h40, 0, 0, 8'hFE);
        // R9 swap, R10 clears, loads
        step(1, 20, 0, 8'hA5, 0, 1, 8'h03);
        step(1, 17, 0, 8'h77, 0, 0, 8'h00);
        step(1, 18, 8'h12, 0, 0, 1, 8'hF0);
        step(1, 6, 0, 0, 8'h00, 1, 8'h02);
        step(1, 16, 8'h9C, 0, 0, 0, 8'h05);
        // R6 logic ops, R2 literal with dest_f set
        step(1, 3, 8'hF0, 0, 8'h0F, 1, 8'h00);
        step(1, 11, 8'h5A, 8'h5A, 0, 1, 8'h03);
        step(1, 12, 0, 8'hFF, 0, 0, 8'h00);
        // R12 undefined codes
        step(1, 25, 8'h11, 8'h22, 8'h33, 1, 8'hA7);
        step(1, 0, 8'h11, 8'h22, 8'h33, 0, 8'h5A);
        step(1, 31, 8'hFF, 8'hFF, 8'hFF, 1, 8'hFF);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 8) != 0, $urandom % 32, $urandom % 256, $urandom % 256,
                 $urandom % 256, $urandom % 2, $urandom % 256);
        end
        step(0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule